// File: doc/BRIEF.md
# Alarm and Timer Interrupt Controller

This block sits beside a clock/calendar counter chain. It holds a programmable alarm and a two-digit BCD timer, keeps two sticky flags and drives an active-low interrupt line. The counter chain supplies the current time and calendar values and a one-cycle strobe per unit. The strobe for a unit is high in the cycle in which that unit's counter already shows its new value. Software writes a small register set through a simple write port.

Three registers are visible to software. The control byte at address 0 holds the timer flag (bit 0), the alarm flag (bit 1) and the enable (bit 2). The mode byte at address 8 holds the interrupt enables, the alarm kind and the timer step unit. The compare bytes sit at addresses 9 to 0xF, and each one is eight above the counter it is matched against. Address 7 loads the timer.

With the enable cleared, the block falls back to a calibration mode. The interrupt line then mirrors a 1 Hz square wave, the two flags toggle as seconds and minutes indicators, and the timer holds its value.

Top module: `alarm_timer_irq`

## Requirements
- R1: After reset the timer reads 00, both flags are 0, the enable is 0, and the mode and compare bytes are 0.
- R2: A write to address 0 loads the timer flag from bit 0, the alarm flag from bit 1 and the enable from bit 2. Address 7 loads the timer. Address 8 loads the mode byte. Addresses 9, A, B, C, D, E and F load the compare bytes for hundredths, seconds, minutes, hours, year/date, weekday/month and timer.
- R3: With the enable set, each selected strobe advances the timer by one in BCD. From 99 it goes to 00 and sets the timer flag.
- R4: Mode bits 2:0 pick the timer strobe: 001 hundredths, 010 seconds, 011 minutes, 100 hours, 101 days. The codes 000, 110 and 111 stop the timer.
- R5: When mode bit 6 is set and a timer step lands on the value in compare byte F, the alarm flag sets.
- R6: Mode bits 5:4 give the alarm kind: 00 none, 01 daily, 10 weekday, 11 dated. Every kind is tested only on a hundredths strobe. A daily alarm fires when hundredths, seconds, minutes and hours all equal their compare bytes.
- R7: A weekday alarm needs the daily match, and it also needs bit w of compare byte E to be set, where w is the weekday in counter bits 7:5 of the weekday/month input. A weekday value of 7 never matches.
- R8: A dated alarm needs the daily match, and it also needs date bits 5:0 and month bits 4:0 to equal their compare bytes. The year bits 7:6 and the weekday bits 7:5 are ignored.
- R9: With the enable set, a flag stays set until software writes 0 to it. A set event in the same cycle as that write wins.
- R10: With the enable set, irq_n is low exactly while the alarm flag is set with mode bit 7 set, or the timer flag is set with mode bit 3 set.
- R11: With the enable clear, irq_n follows sq_1hz. The timer flag toggles on each seconds strobe, the alarm flag toggles on each minutes strobe, and the timer does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| cnt_hund | input | 8 | Hundredths counter, BCD |
| cnt_sec | input | 8 | Seconds counter, BCD |
| cnt_min | input | 8 | Minutes counter, BCD |
| cnt_hour | input | 8 | Hours counter including format bits |
| cnt_yd | input | 8 | Year (7:6) and date (5:0) |
| cnt_wm | input | 8 | Weekday (7:5) and month (4:0) |
| tick_hund | input | 1 | Hundredths strobe |
| tick_sec | input | 1 | Seconds strobe |
| tick_min | input | 1 | Minutes strobe |
| tick_hour | input | 1 | Hours strobe |
| tick_day | input | 1 | Days strobe |
| sq_1hz | input | 1 | 1 Hz square wave |
| timer_val | output | 8 | Timer, BCD |
| timer_flag | output | 1 | Timer flag |
| alarm_flag | output | 1 | Alarm flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The timer is walked through a full 100-step cycle from 00. Each step is checked against a BCD value computed in the bench, which separates digit carry from wrap. All eight step codes are crossed with all five strobes, which exposes any mis-decoded unit. The four alarm kinds are crossed with six counter patterns: an exact match, a time mismatch in the lowest field, one in the highest field, and a date, a month or a weekday difference. This tells apart which fields each kind compares and which it ignores. Separate sequences cover a clear that collides with a set event, the effect of each interrupt enable, and calibration-mode toggling.

// File: rtl/alarm_timer_irq.sv
module alarm_timer_irq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] cnt_hund,
  input  logic [DW-1:0] cnt_sec,
  input  logic [DW-1:0] cnt_min,
  input  logic [DW-1:0] cnt_hour,
  input  logic [DW-1:0] cnt_yd,
  input  logic [DW-1:0] cnt_wm,
  input  logic          tick_hund,
  input  logic          tick_sec,
  input  logic          tick_min,
  input  logic          tick_hour,
  input  logic          tick_day,
  input  logic          sq_1hz,
  output logic [DW-1:0] timer_val,
  output logic          timer_flag,
  output logic          alarm_flag,
  output logic          irq_n
);
  localparam logic [3:0] A_CTL = 4'h0;
  localparam logic [3:0] A_TMR = 4'h7;
  localparam logic [3:0] A_MODE = 4'h8;
  localparam logic [3:0] A_CMP0 = 4'h9;
  localparam int NCMP = 7;
  localparam logic [DW-1:0] TOP = DW'(8'h99);

  logic          alarm_en;
  logic [DW-1:0] mode;
  logic [DW-1:0] cmp [NCMP];

  wire wr_ctl = wr_en && wr_addr == A_CTL;
  wire wr_tmr = wr_en && wr_addr == A_TMR;
  wire wr_mode = wr_en && wr_addr == A_MODE;

  function automatic logic [DW-1:0] bcd_inc(input logic [DW-1:0] v);
    logic [3:0] lo, hi;
    lo = v[3:0];
    hi = v[7:4];
    if (v == TOP) return '0;
    if (lo >= 4'd9) return DW'({hi + 4'd1, 4'd0});
    return DW'({hi, lo + 4'd1});
  endfunction

  logic tick_sel;
  always_comb begin
    case (mode[2:0])
      3'b001:  tick_sel = tick_hund;
      3'b010:  tick_sel = tick_sec;
      3'b011:  tick_sel = tick_min;
      3'b100:  tick_sel = tick_hour;
      3'b101:  tick_sel = tick_day;
      default: tick_sel = 1'b0;
    endcase
  end

  wire           tmr_step = alarm_en && tick_sel;
  wire [DW-1:0]  tmr_next = bcd_inc(timer_val);
  wire           tmr_wrap = tmr_step && timer_val == TOP;
  wire           tmr_hit  = tmr_step && mode[6] && tmr_next == cmp[6];

  wire       time_eq = cnt_hund == cmp[0] && cnt_sec == cmp[1] &&
                       cnt_min == cmp[2] && cnt_hour == cmp[3];
  wire [2:0] wday    = cnt_wm[7:5];
  wire       wday_ok = wday != 3'd7 && cmp[5][wday];
  wire       date_ok = cnt_yd[5:0] == cmp[4][5:0] && cnt_wm[4:0] == cmp[5][4:0];

  logic kind_ok;
  always_comb begin
    case (mode[5:4])
      2'b01:   kind_ok = 1'b1;
      2'b10:   kind_ok = wday_ok;
      2'b11:   kind_ok = date_ok;
      default: kind_ok = 1'b0;
    endcase
  end

  wire clk_hit = alarm_en && tick_hund && time_eq && kind_ok;
  wire a_set   = tmr_hit || clk_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_en <= 1'b0;
      mode     <= '0;
      for (int i = 0; i < NCMP; i++) cmp[i] <= '0;
    end else if (wr_en) begin
      if (wr_ctl) alarm_en <= wr_data[2];
      if (wr_mode) mode <= wr_data;
      for (int i = 0; i < NCMP; i++)
        if (wr_addr == A_CMP0 + 4'(i)) cmp[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timer_val <= '0;
    else if (wr_tmr) timer_val <= wr_data;
    else if (tmr_step) timer_val <= tmr_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_flag <= 1'b0;
      alarm_flag <= 1'b0;
    end else if (wr_ctl) begin
      timer_flag <= wr_data[0] || tmr_wrap;
      alarm_flag <= wr_data[1] || a_set;
    end else if (alarm_en) begin
      timer_flag <= timer_flag || tmr_wrap;
      alarm_flag <= alarm_flag || a_set;
    end else begin
      if (tick_sec) timer_flag <= !timer_flag;
      if (tick_min) alarm_flag <= !alarm_flag;
    end
  end

  assign irq_n = alarm_en ? !((alarm_flag && mode[7]) || (timer_flag && mode[3])) : sq_1hz;

  p_wrap_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap && !wr_tmr |=> timer_val == '0 && timer_flag);
  p_timer_alarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_hit |=> alarm_flag);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_en && alarm_flag && !wr_ctl |=> alarm_flag);
  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_en && alarm_flag && mode[7] |-> !irq_n);
  p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en && !wr_tmr |=> $stable(timer_val));
  p_calib_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en && tick_sec && !wr_ctl |=> timer_flag != $past(timer_flag));
endmodule

// File: tb/alarm_timer_irq_bench.sv
module alarm_timer_irq_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, sq_1hz = 0;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] c_h = 0, c_s = 0, c_m = 0, c_hr = 0, c_yd = 0, c_wm = 0;
  logic [4:0] ticks = 0;
  logic [7:0] timer_val;
  logic timer_flag, alarm_flag, irq_n;
  int vecs = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alarm_timer_irq u_alarm_timer_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_hund(c_h), .cnt_sec(c_s), .cnt_min(c_m), .cnt_hour(c_hr), .cnt_yd(c_yd), .cnt_wm(c_wm),
    .tick_hund(ticks[0]), .tick_sec(ticks[1]), .tick_min(ticks[2]), .tick_hour(ticks[3]),
    .tick_day(ticks[4]), .sq_1hz(sq_1hz),
    .timer_val(timer_val), .timer_flag(timer_flag), .alarm_flag(alarm_flag), .irq_n(irq_n));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic tick(input logic [4:0] m);
    ticks = m;
    @(posedge clk); #2;
    ticks = 0;
  endtask

  function automatic logic [7:0] to_bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    chk("R1 timer", timer_val, 8'h00);
    chk("R1 tflag", {7'd0, timer_flag}, 8'd0);
    chk("R1 aflag", {7'd0, alarm_flag}, 8'd0);
    // R11 calibration mode
    sq_1hz = 1; #1 chk("R11 irq hi", {7'd0, irq_n}, 8'd1);
    sq_1hz = 0; #1 chk("R11 irq lo", {7'd0, irq_n}, 8'd0);
    tick(5'b00010); chk("R11 sec toggle", {7'd0, timer_flag}, 8'd1);
    tick(5'b00010); chk("R11 sec toggle back", {7'd0, timer_flag}, 8'd0);
    tick(5'b00100); chk("R11 min toggle", {7'd0, alarm_flag}, 8'd1);
    wr(4'h8, 8'h01);
    tick(5'b00001); chk("R11 timer halted", timer_val, 8'h00);
    // R2 enable and clear via control byte
    wr(4'h0, 8'h04);
    chk("R2 aflag cleared", {7'd0, alarm_flag}, 8'd0);
    sq_1hz = 0; #1 chk("R10 no enables irq", {7'd0, irq_n}, 8'd1);
    // R3 full sweep
    wr(4'h7, 8'h00);
    for (int n = 1; n <= 100; n++) begin
      tick(5'b00001);
      chk("R3 bcd count", timer_val, to_bcd(n % 100));
      chk("R3 wrap flag", {7'd0, timer_flag}, (n >= 100) ? 8'd1 : 8'd0);
    end
    // R9 sticky, clear, set wins
    tick(5'b00001); tick(5'b00001);
    chk("R9 sticky", {7'd0, timer_flag}, 8'd1);
    wr(4'h0, 8'h04); chk("R9 clear", {7'd0, timer_flag}, 8'd0);
    wr(4'h7, 8'h99);
    ticks = 5'b00001; wr(4'h0, 8'h04); ticks = 0;
    chk("R9 set wins flag", {7'd0, timer_flag}, 8'd1);
    chk("R9 set wins timer", timer_val, 8'h00);
    // R10 timer interrupt enable
    wr(4'h8, 8'h09); chk("R10 timer irq", {7'd0, irq_n}, 8'd0);
    wr(4'h8, 8'h01); chk("R10 irq masked", {7'd0, irq_n}, 8'd1);
    wr(4'h0, 8'h04);
    // R4 resolution x strobe sweep
    for (int code = 0; code < 8; code++)
      for (int t = 0; t < 5; t++) begin
        wr(4'h7, 8'h42);
        wr(4'h8, 8'(code));
        tick(5'(1 << t));
        chk("R4 step select", timer_val, (code == t + 1) ? 8'h43 : 8'h42);
      end
    // R5 timer alarm, compare at F (R2)
    wr(4'h0, 8'h04);
    wr(4'h8, 8'hC1); wr(4'hF, 8'h05); wr(4'h7, 8'h03);
    tick(5'b00001); chk("R5 no hit yet", {7'd0, alarm_flag}, 8'd0);
    tick(5'b00001); chk("R5 hit", {7'd0, alarm_flag}, 8'd1);
    chk("R10 alarm irq", {7'd0, irq_n}, 8'd0);
    wr(4'h0, 8'h04); chk("R9 alarm clear", {7'd0, alarm_flag}, 8'd0);
    wr(4'h8, 8'h01); wr(4'h7, 8'h04);
    tick(5'b00001); chk("R5 disabled", {7'd0, alarm_flag}, 8'd0);
    // R6 R7 R8 alarm kinds x patterns
    wr(4'h9, 8'h37); wr(4'hA, 8'h12); wr(4'hB, 8'h45); wr(4'hC, 8'h08);
    wr(4'hD, {2'd2, 6'h15});
    for (int md = 0; md < 4; md++) begin
      wr(4'h8, 8'(md << 4));
      wr(4'hE, (md == 2) ? 8'h08 : {3'd5, 5'h06});
      for (int p = 0; p < 6; p++) begin
        logic teq, fire;
        c_h = (p == 1) ? 8'h38 : 8'h37;
        c_s = 8'h12; c_m = 8'h45;
        c_hr = (p == 2) ? 8'h09 : 8'h08;
        c_yd = {2'd1, (p == 3) ? 6'h16 : 6'h15};
        c_wm = {(p == 5) ? 3'd2 : 3'd3, (p == 4) ? 5'h07 : 5'h06};
        teq = (p != 1) && (p != 2);
        case (md)
          1: fire = teq;
          2: fire = teq && c_wm[7:5] == 3'd3;
          3: fire = teq && c_yd[5:0] == 6'h15 && c_wm[4:0] == 5'h06;
          default: fire = 0;
        endcase
        wr(4'h0, 8'h04);
        tick(5'b00001);
        if (md == 2) chk("R7 weekday alarm", {7'd0, alarm_flag}, {7'd0, fire});
        else if (md == 3) chk("R8 dated alarm", {7'd0, alarm_flag}, {7'd0, fire});
        else chk("R6 daily/none alarm", {7'd0, alarm_flag}, {7'd0, fire});
      end
    end
    finish_run();
  end
endmodule